// File: doc/BRIEF.md
# Comparison Register Save/Restore Sequencer

This block carries out one "save or restore a list of comparison registers" operation as a series of memory word accesses. A comparison register holds 16 bits, and a memory word holds 32 bits. Each access therefore moves two registers at once, and a list of N registers needs ceil(N/2) accesses. The caller gives a bit mask that selects the registers, a direction bit, and a base address, which normally comes from the stack pointer. The caller then pulses `start`.

While the operation runs, the sequencer walks the mask from the lowest set bit upward. For a save, it reads two register file entries at a time through two combinational read ports and packs them into the store data. For a restore, it splits each returned word into two halves and writes them to the register file through two write ports. The memory side uses a simple request/ready handshake. The register file storage and the memory system lie outside this block.

Top module: `cmpspill_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `mem_req`, `done`, `rf_we0` and `rf_we1` are low.
- R2: Selected registers are transferred in ascending index order. Each word carries the two lowest indices still pending. The lower index sits in data bits 15-0 and the higher index in bits 31-16, for both store data and load data.
- R3: The first access uses `base_addr`. Each later access uses the previous address plus 4.
- R4: When an odd number of registers is selected, the final stored word has zero in bits 31-16. On a load, those bits are ignored: only the last register is written, and no other register changes.
- R5: On a load, the register file writes happen in the cycle in which `mem_req` and `mem_ready` are both high. Write port 0 carries the lower index with bits 15-0, and write port 1 carries the higher index with bits 31-16.
- R6: While `mem_req` is high and `mem_ready` is low, the next cycle keeps `mem_req` high and keeps `mem_addr`, `mem_wdata` and `mem_we` unchanged.
- R7: `done` is high for exactly one cycle. That cycle is the one after the last accepted access, and `busy` is low in it. The number of accepted accesses is ceil(N/2).
- R8: A start with an empty mask raises `done` in the next cycle and makes no memory request.
- R9: A `start` pulse while the block is busy is ignored. The running operation finishes unchanged.
- R10: `mem_we` is 1 for a save (`is_load`=0) and 0 for a restore during every access. A save performs no register file writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| is_load | input | 1 | 1 = restore from memory, 0 = save to memory |
| reg_mask | input | NREGS | One bit per comparison register to transfer |
| base_addr | input | ADDR_W | Address of the first word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 2*CREG_W | Store data (two packed registers) |
| mem_rdata | input | 2*CREG_W | Load data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts / completes the access this cycle |
| rf_rd_idx0 | output | log2(NREGS) | Read index, lower register of the pair |
| rf_rd_data0 | input | CREG_W | Read data for rf_rd_idx0 |
| rf_rd_idx1 | output | log2(NREGS) | Read index, upper register of the pair |
| rf_rd_data1 | input | CREG_W | Read data for rf_rd_idx1 |
| rf_we0 | output | 1 | Write enable, lower half |
| rf_widx0 | output | log2(NREGS) | Write index, lower half |
| rf_wdata0 | output | CREG_W | Write data, lower half |
| rf_we1 | output | 1 | Write enable, upper half |
| rf_widx1 | output | log2(NREGS) | Write index, upper half |
| rf_wdata1 | output | CREG_W | Write data, upper half |

## Verification
The first request appears in the cycle after the one in which `start` is sampled. Register file writes for a restore appear in the same cycle as the accepted handshake. `done` appears exactly one cycle after the last accepted handshake, or one cycle after `start` when the mask is empty. The bench drives inputs shortly after the rising edge and samples every output at the falling edge, numbering cycles at that point. It compares the cycle of `done` with the recorded cycle of `start` or of the final handshake using these fixed offsets, never with a wait-until.

// File: rtl/cmpspill_pkg.sv
package cmpspill_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_XFER = 1'b1
  } seq_state_e;

endpackage

// File: rtl/cmpspill_rst_sync.sv
module cmpspill_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cmpspill_lsb.sv
module cmpspill_lsb #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  logic [N-1:0] below;
  logic [N-1:0] onehot;

  assign below[0]  = 1'b0;
  assign onehot[0] = vec[0];

  for (genvar g = 1; g < N; g++) begin : g_chain
    assign below[g]  = below[g-1] | vec[g-1];
    assign onehot[g] = vec[g] & ~below[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end

  assign found = |vec;

endmodule

// File: rtl/cmpspill_pick.sv
module cmpspill_pick #(
  parameter int NREGS = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] pend,
  output logic             has0,
  output logic [IDX_W-1:0] idx0,
  output logic             has1,
  output logic [IDX_W-1:0] idx1,
  output logic [NREGS-1:0] rest
);

  logic [NREGS-1:0] after_first;
  logic [NREGS-1:0] clr0;
  logic [NREGS-1:0] clr1;

  cmpspill_lsb #(.N(NREGS)) u_first (
    .vec   (pend),
    .found (has0),
    .idx   (idx0)
  );

  assign clr0        = {{(NREGS-1){1'b0}}, has0} << idx0;
  assign after_first = pend & ~clr0;

  cmpspill_lsb #(.N(NREGS)) u_second (
    .vec   (after_first),
    .found (has1),
    .idx   (idx1)
  );

  assign clr1 = {{(NREGS-1){1'b0}}, has1} << idx1;
  assign rest = after_first & ~clr1;

endmodule

// File: rtl/cmpspill_pack.sv
module cmpspill_pack #(
  parameter int CREG_W = 16,
  localparam int WORD_W = 2 * CREG_W
) (
  input  logic              xfer,
  input  logic              load_mode,
  input  logic              mem_ready,
  input  logic              has0,
  input  logic              has1,
  input  logic [CREG_W-1:0] rd0,
  input  logic [CREG_W-1:0] rd1,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] wdata,
  output logic              we0,
  output logic              we1,
  output logic [CREG_W-1:0] wd0,
  output logic [CREG_W-1:0] wd1
);

  logic [CREG_W-1:0] upper_src;

  // odd tail: the upper half of the last stored word is forced to zero
  assign upper_src = has1 ? rd1 : '0;
  assign wdata     = load_mode ? '0 : {upper_src, rd0};

  assign we0 = xfer & load_mode & mem_ready & has0;
  assign we1 = we0 & has1;
  assign wd0 = rdata[CREG_W-1:0];
  assign wd1 = rdata[WORD_W-1:CREG_W];

endmodule

// File: rtl/cmpspill_ctrl.sv
module cmpspill_ctrl
  import cmpspill_pkg::*;
#(
  parameter int NREGS  = 16,
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  localparam int STEP  = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_load,
  input  logic [NREGS-1:0]  reg_mask,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              mem_ready,
  input  logic [NREGS-1:0]  rest_mask,
  output logic [NREGS-1:0]  pend_mask,
  output logic [ADDR_W-1:0] addr,
  output logic              load_mode,
  output logic              xfer,
  output logic              done
);

  seq_state_e        st_q, st_d;
  logic [NREGS-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              load_q, load_d;
  logic              done_q, done_d;
  logic              rem_en, addr_en, load_en;

  always_comb begin
    st_d    = st_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    load_d  = load_q;
    done_d  = 1'b0;
    rem_en  = 1'b0;
    addr_en = 1'b0;
    load_en = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          addr_en = 1'b1;
          rem_en  = 1'b1;
          load_d  = is_load;
          addr_d  = base_addr;
          rem_d   = reg_mask;
          if (reg_mask == '0) done_d = 1'b1;
          else                st_d   = SEQ_XFER;
        end
      end
      SEQ_XFER: begin
        if (mem_ready) begin
          rem_en  = 1'b1;
          addr_en = 1'b1;
          rem_d   = rest_mask;
          addr_d  = addr_q + ADDR_W'(STEP);
          if (rest_mask == '0) begin
            st_d   = SEQ_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
      load_q <= 1'b0;
    end else begin
      if (rem_en)  rem_q  <= rem_d;
      if (addr_en) addr_q <= addr_d;
      if (load_en) load_q <= load_d;
    end
  end

  assign pend_mask = rem_q;
  assign addr      = addr_q;
  assign load_mode = load_q;
  assign xfer      = (st_q == SEQ_XFER);
  assign done      = done_q;

endmodule

// File: rtl/cmpspill_seq.sv
module cmpspill_seq #(
  parameter int NREGS  = 16,
  parameter int CREG_W = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W  = $clog2(NREGS),
  localparam int WORD_W = 2 * CREG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_load,
  input  logic [NREGS-1:0]  reg_mask,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [IDX_W-1:0]  rf_rd_idx0,
  input  logic [CREG_W-1:0] rf_rd_data0,
  output logic [IDX_W-1:0]  rf_rd_idx1,
  input  logic [CREG_W-1:0] rf_rd_data1,
  output logic              rf_we0,
  output logic [IDX_W-1:0]  rf_widx0,
  output logic [CREG_W-1:0] rf_wdata0,
  output logic              rf_we1,
  output logic [IDX_W-1:0]  rf_widx1,
  output logic [CREG_W-1:0] rf_wdata1
);

  logic             rst_n_int;
  logic [NREGS-1:0] pend_mask;
  logic [NREGS-1:0] rest_mask;
  logic             pick_has0;
  logic             pick_has1;
  logic [IDX_W-1:0] pick_idx0;
  logic [IDX_W-1:0] pick_idx1;
  logic             load_mode;
  logic             xfer;

  cmpspill_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cmpspill_ctrl #(
    .NREGS  (NREGS),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .is_load   (is_load),
    .reg_mask  (reg_mask),
    .base_addr (base_addr),
    .mem_ready (mem_ready),
    .rest_mask (rest_mask),
    .pend_mask (pend_mask),
    .addr      (mem_addr),
    .load_mode (load_mode),
    .xfer      (xfer),
    .done      (done)
  );

  cmpspill_pick #(.NREGS(NREGS)) u_pick (
    .pend (pend_mask),
    .has0 (pick_has0),
    .idx0 (pick_idx0),
    .has1 (pick_has1),
    .idx1 (pick_idx1),
    .rest (rest_mask)
  );

  cmpspill_pack #(.CREG_W(CREG_W)) u_pack (
    .xfer      (xfer),
    .load_mode (load_mode),
    .mem_ready (mem_ready),
    .has0      (pick_has0),
    .has1      (pick_has1),
    .rd0       (rf_rd_data0),
    .rd1       (rf_rd_data1),
    .rdata     (mem_rdata),
    .wdata     (mem_wdata),
    .we0       (rf_we0),
    .we1       (rf_we1),
    .wd0       (rf_wdata0),
    .wd1       (rf_wdata1)
  );

  assign busy       = xfer;
  assign mem_req    = xfer;
  assign mem_we     = ~load_mode;
  assign rf_rd_idx0 = pick_idx0;
  assign rf_rd_idx1 = pick_idx1;
  assign rf_widx0   = pick_idx0;
  assign rf_widx1   = pick_idx1;

endmodule

// File: rtl/cmpspill_chk.sv
module cmpspill_chk #(
  parameter int NREGS  = 16,
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [NREGS-1:0]  reg_mask,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              rf_we0,
  input logic              rf_we1,
  input logic [IDX_W-1:0]  rf_rd_idx0,
  input logic [IDX_W-1:0]  rf_rd_idx1,
  input logic              pair_hit
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !rf_we0 && !rf_we1));

  p_pair_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && pair_hit) |-> (rf_rd_idx1 > rf_rd_idx0));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_req && mem_ready) && mem_req) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4)));

  p_upper_needs_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we1 |-> rf_we0);

  p_load_on_handshake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we0 |-> (mem_req && mem_ready && !mem_we));

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_req && mem_ready) && !mem_req) |-> done);

  p_empty_list_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && reg_mask == '0) |=> (done && !mem_req));

  p_dir_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_we));

endmodule

bind cmpspill_seq cmpspill_chk #(
  .NREGS  (NREGS),
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .reg_mask   (reg_mask),
  .busy       (busy),
  .done       (done),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready),
  .rf_we0     (rf_we0),
  .rf_we1     (rf_we1),
  .rf_rd_idx0 (rf_rd_idx0),
  .rf_rd_idx1 (rf_rd_idx1),
  .pair_hit   (pick_has1)
);

// File: tb/cmpspill_seq_test.sv
`timescale 1ns/1ps
module cmpspill_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, is_load;
  logic [15:0] reg_mask;
  logic [31:0] base_addr;
  logic        busy, done, mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  rf_rd_idx0, rf_rd_idx1, rf_widx0, rf_widx1;
  logic [15:0] rf_rd_data0, rf_rd_data1, rf_wdata0, rf_wdata1;
  logic        rf_we0, rf_we1;

  always #2.5 clk = ~clk;

  cmpspill_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load),
    .reg_mask(reg_mask), .base_addr(base_addr), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rf_rd_idx0(rf_rd_idx0), .rf_rd_data0(rf_rd_data0),
    .rf_rd_idx1(rf_rd_idx1), .rf_rd_data1(rf_rd_data1),
    .rf_we0(rf_we0), .rf_widx0(rf_widx0), .rf_wdata0(rf_wdata0),
    .rf_we1(rf_we1), .rf_widx1(rf_widx1), .rf_wdata1(rf_wdata1)
  );

  // bench-side register file and memory
  logic [15:0] cregs [16];
  logic [31:0] mem   [64];
  assign rf_rd_data0 = cregs[rf_rd_idx0];
  assign rf_rd_data1 = cregs[rf_rd_idx1];
  assign mem_rdata   = mem[mem_addr[7:2]];

  int n_chk = 0;
  int n_bad = 0;

  // monitor state (sampled at the falling edge)
  int          cyc = 0;
  int          hs_n, req_n, rfw_n, done_n, hold_bad;
  int          last_hs, done_cyc;
  bit          done_seen;
  logic [31:0] log_addr [16];
  logic [31:0] log_wd   [16];
  logic        log_we   [16];
  bit          held;
  logic [31:0] h_addr, h_wd;
  logic        h_we;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (held && (!mem_req || mem_addr != h_addr || mem_wdata != h_wd || mem_we != h_we))
      hold_bad = hold_bad + 1;
    held   = mem_req && !mem_ready;
    h_addr = mem_addr;
    h_wd   = mem_wdata;
    h_we   = mem_we;
    if (mem_req) req_n = req_n + 1;
    if (mem_req && mem_ready) begin
      if (hs_n < 16) begin
        log_addr[hs_n] = mem_addr;
        log_wd[hs_n]   = mem_wdata;
        log_we[hs_n]   = mem_we;
      end
      hs_n    = hs_n + 1;
      last_hs = cyc;
    end
    if (rf_we0) begin cregs[rf_widx0] = rf_wdata0; rfw_n = rfw_n + 1; end
    if (rf_we1) cregs[rf_widx1] = rf_wdata1;
    if (done) begin done_n = done_n + 1; done_cyc = cyc; done_seen = 1'b1; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] seed(input int i);
    return 16'(16'h3C00 + i * 16'h0107);
  endfunction

  // {is_load, mask, base, ready pattern}
  localparam logic [56:0] VEC [8] = '{
    {1'b0, 16'h0003, 32'h0000_1000, 8'hFF},
    {1'b0, 16'h8421, 32'h0000_1020, 8'hA5},
    {1'b0, 16'h0007, 32'h0000_1040, 8'h0F},
    {1'b0, 16'hFFFF, 32'h0000_10E0, 8'hFF},
    {1'b1, 16'h0003, 32'h0000_1000, 8'hFF},
    {1'b1, 16'h1248, 32'h0000_1080, 8'h33},
    {1'b1, 16'h8000, 32'h0000_10C0, 8'h96},
    {1'b1, 16'hFFFF, 32'h0000_1000, 8'h6D}
  };

  task automatic run_op(input logic ld, input logic [15:0] mask, input logic [31:0] base,
                        input logic [7:0] pat, input bit inj, input string tag);
    int          lst [16];
    int          n = 0;
    int          words, sc, ph;
    logic [15:0] exp_reg [16];
    for (int i = 0; i < 16; i++) if (mask[i]) begin lst[n] = i; n = n + 1; end
    words = (n + 1) / 2;
    for (int i = 0; i < 16; i++) cregs[i] = ld ? 16'(16'hEE00 + i) : seed(i);
    for (int j = 0; j < 64; j++) mem[j] = {16'(16'hA001 + 2 * j), 16'(16'hA000 + 2 * j)};
    for (int i = 0; i < 16; i++) exp_reg[i] = cregs[i];
    for (int k = 0; k < n; k++) begin
      logic [31:0] w = mem[6'((base + 32'(4 * (k / 2))) >> 2)];
      exp_reg[lst[k]] = (k % 2 == 0) ? w[15:0] : w[31:16];
    end

    @(posedge clk); #1;
    hs_n = 0; req_n = 0; rfw_n = 0; done_n = 0; hold_bad = 0; done_seen = 1'b0; held = 1'b0;
    start = 1'b1; is_load = ld; reg_mask = mask; base_addr = base; mem_ready = 1'b0;
    sc = cyc + 1;
    ph = 0;
    for (int t = 0; t < 300 && !done_seen; t++) begin
      @(posedge clk); #1;
      start = 1'b0;
      if (inj && t == 2) begin
        start = 1'b1; reg_mask = 16'h000F; base_addr = 32'h0000_1000; is_load = ~ld;
      end
      mem_ready = pat[ph];
      ph = (ph + 1) % 8;
    end
    repeat (3) begin @(posedge clk); #1; start = 1'b0; mem_ready = 1'b0; end

    chk(hs_n == words, {tag, " R7 access count"}, 32'(hs_n), 32'(words));
    chk(done_n == 1, {tag, " R7 single done"}, 32'(done_n), 32'd1);
    if (words == 0) begin
      chk(done_cyc == sc + 1, {tag, " R8 done cycle"}, 32'(done_cyc), 32'(sc + 1));
      chk(req_n == 0, {tag, " R8 no request"}, 32'(req_n), 32'd0);
    end else begin
      chk(done_cyc == last_hs + 1, {tag, " R7 done cycle"}, 32'(done_cyc), 32'(last_hs + 1));
    end
    chk(hold_bad == 0, {tag, " R6 hold while stalled"}, 32'(hold_bad), 32'd0);
    for (int k = 0; k < words && k < 16; k++) begin
      chk(log_addr[k] == base + 32'(4 * k), {tag, " R3 address"}, log_addr[k], base + 32'(4 * k));
      chk(log_we[k] == !ld, {tag, " R10 direction"}, 32'(log_we[k]), 32'(!ld));
      if (!ld) begin
        logic [31:0] e;
        e[15:0]  = seed(lst[2 * k]);
        e[31:16] = (2 * k + 1 < n) ? seed(lst[2 * k + 1]) : 16'h0000;
        chk(log_wd[k] == e, (2 * k + 1 < n) ? {tag, " R2 store packing"} : {tag, " R4 odd store tail"},
            log_wd[k], e);
      end
    end
    if (!ld) chk(rfw_n == 0, {tag, " R10 no file write on save"}, 32'(rfw_n), 32'd0);
    else
      for (int i = 0; i < 16; i++)
        chk(cregs[i] == exp_reg[i], mask[i] ? {tag, " R5 restored value"} : {tag, " R4 untouched register"},
            32'(cregs[i]), 32'(exp_reg[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad = n_bad + 1;
    $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_load = 1'b0; reg_mask = '0; base_addr = '0; mem_ready = 1'b0;
    for (int i = 0; i < 16; i++) cregs[i] = 16'h0;
    for (int j = 0; j < 64; j++) mem[j] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset (busy/req)", {busy, mem_req}, 32'd0);
    chk(!done && !rf_we0 && !rf_we1, "R1 idle after reset (done/we)", {done, rf_we0, rf_we1}, 32'd0);

    for (int v = 0; v < 8; v++)
      run_op(VEC[v][56], VEC[v][55:40], VEC[v][39:8], VEC[v][7:0], 1'b0, $sformatf("vec%0d", v));

    // empty list
    run_op(1'b0, 16'h0000, 32'h0000_1000, 8'hFF, 1'b0, "empty R8");
    run_op(1'b1, 16'h0000, 32'h0000_1000, 8'hFF, 1'b0, "empty-load R8");
    // start pulsed while busy must be ignored
    run_op(1'b0, 16'h00F0, 32'h0000_1040, 8'h88, 1'b1, "busy-start R9");
    run_op(1'b1, 16'h0E00, 32'h0000_1060, 8'h44, 1'b1, "busy-start-load R9");
    // single register at the top index, save
    run_op(1'b0, 16'h8000, 32'h0000_10FC, 8'h01, 1'b0, "top-single R4");

    @(negedge clk);
    chk(!busy && !mem_req && !done, "R1 idle at end", {busy, mem_req, done}, 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule